// File: doc/BRIEF.md
# Vector Strip-Mining Length Sequencer

This block splits a loop of `n` elements into pieces that a vector unit can process, where the unit takes at most `MVL` elements per operation. A single-cycle `start` pulse loads the loop count. The block then offers a series of chunks, one at a time, over a valid/ready handshake. Each chunk is a starting element index together with a vector length.

The short leftover piece, `n mod MVL` elements, is offered first. Every chunk after it is exactly `MVL` long, so the downstream unit runs full-width operations for the rest of the loop. When the final chunk has been accepted, a `done` flag rises. It stays high until the next start. A loop count of zero produces no chunk at all and raises `done` straight away.

Top module: `strip_seq`

## Requirements
- R1: After reset, `chunk_valid` and `done` are low.
- R2: The first chunk of a loop starts at index 0, and its length is `n mod MVL` (MVL = 16 by default) when that value is nonzero.
- R3: When `n` is a nonzero multiple of MVL, the first chunk is MVL long, and no chunk ever has length zero.
- R4: Every chunk after the first has length exactly MVL.
- R5: The start index of each chunk equals the previous chunk's start index plus the previous chunk's length. The lengths of a loop's chunks sum to `n`.
- R6: While `chunk_valid` is high and `chunk_ready` is low, `chunk_base` and `chunk_len` hold steady. A chunk counts as accepted on a clock edge where both are high, and the next chunk is presented from the following cycle.
- R7: A start with `n = 0` raises `done` on the cycle after the start edge, and no chunk is presented.
- R8: `done` rises on the cycle after the final chunk is accepted. At that point `chunk_valid` is low, and `done` and `chunk_valid` are never high together.
- R9: A `start` pulse that arrives while chunks are still pending is ignored. The current sequence continues unchanged.
- R10: `done` stays high until a new start is accepted. That start clears `done`, unless the new `n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `total` and begin a loop |
| total | input | NW | Loop element count `n` |
| chunk_ready | input | 1 | Consumer accepts the current chunk |
| chunk_valid | output | 1 | A chunk is on offer |
| chunk_base | output | NW | Starting element index of the chunk |
| chunk_len | output | $clog2(MVL+1) | Vector length of the chunk |
| done | output | 1 | All chunks of the loop have been accepted |

## Verification
The bench targets the following cases and the faulty behaviour each would expose:
- Counts that are exact multiples of 16: a design that gets the remainder case wrong emits a zero-length chunk there.
- Counts of 1, 15 and 17: an off-by-one in the remaining-count test either drops the last chunk or adds an extra one.
- A loop count of zero: a faulty design hangs with `chunk_valid` high, or emits a phantom chunk.
- Back-pressure from random deassertion of `chunk_ready`: this catches chunks that advance without a handshake.
- Stray start pulses in mid-sequence: these catch a design that reloads its state on a start that should be ignored.

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int MVL = 16,
  parameter int NW  = 16,
  localparam int LW = $clog2(MVL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] total,
  input  logic          chunk_ready,
  output logic          chunk_valid,
  output logic [NW-1:0] chunk_base,
  output logic [LW-1:0] chunk_len,
  output logic          done
);

  logic          busy;
  logic [NW-1:0] left;
  logic [NW-1:0] rem;
  logic [LW-1:0] first_len;
  logic          fire;

  assign rem         = total % NW'(MVL);
  assign first_len   = (rem == '0) ? LW'(MVL) : LW'(rem);
  assign fire        = busy & chunk_ready;
  assign chunk_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      left       <= '0;
      chunk_base <= '0;
      chunk_len  <= '0;
    end else if (!busy && start) begin
      busy       <= (total != '0);
      done       <= (total == '0);
      left       <= total;
      chunk_base <= '0;
      chunk_len  <= first_len;
    end else if (fire) begin
      chunk_base <= chunk_base + NW'(chunk_len);
      left       <= left - NW'(chunk_len);
      chunk_len  <= LW'(MVL);
      if (left == NW'(chunk_len)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  p_len_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid |-> (chunk_len != '0 && chunk_len <= LW'(MVL)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready) |=> (chunk_valid && $stable(chunk_base) && $stable(chunk_len)));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_ready) |=> (!chunk_valid || chunk_base == $past(chunk_base) + NW'($past(chunk_len))));

  p_full_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && chunk_ready) |=> (!chunk_valid || chunk_len == LW'(MVL)));

  p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !chunk_valid);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_valid && !chunk_ready && start) |=> $stable(chunk_base));

endmodule

// File: tb/strip_seq_test.sv
module strip_seq_test;
  localparam int MVL = 16;
  localparam int NW  = 16;
  localparam int LW  = $clog2(MVL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW-1:0] total = '0;
  logic          chunk_ready = 1'b0;
  logic          chunk_valid;
  logic [NW-1:0] chunk_base;
  logic [LW-1:0] chunk_len;
  logic          done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit wd_hit = 0;

  strip_seq #(.MVL(MVL), .NW(NW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .total(total),
    .chunk_ready(chunk_ready), .chunk_valid(chunk_valid),
    .chunk_base(chunk_base), .chunk_len(chunk_len), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !wd_hit) begin
      wd_hit = 1;
      errors++; checks++;
      $display("FAIL watchdog: cycles=%0d expected < 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int first_len(int n);
    return (n % MVL == 0) ? MVL : n % MVL;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int n, int ready_pct, bit stray);
    int exp_base = 0;
    int exp_len  = first_len(n);
    int left     = n;
    int sum      = 0;
    @(negedge clk);
    start = 1'b1; total = NW'(n);
    @(negedge clk);
    start = 1'b0; total = NW'($urandom % 500);
    if (n == 0) begin
      chk(done == 1'b1, "R7 done", int'(done), 1);
      chk(chunk_valid == 1'b0, "R7 no chunk", int'(chunk_valid), 0);
      return;
    end
    chk(done == 1'b0, "R10 done cleared", int'(done), 0);
    while (left > 0) begin
      chk(chunk_valid == 1'b1, "R8 valid", int'(chunk_valid), 1);
      chk(int'(chunk_base) == exp_base, (exp_base == 0) ? "R2 base" : "R5 base", int'(chunk_base), exp_base);
      chk(int'(chunk_len) == exp_len, (exp_base == 0) ? "R2/R3 len" : "R4 len", int'(chunk_len), exp_len);
      chk(done == 1'b0, "R8 done low", int'(done), 0);
      chunk_ready = (($urandom % 100) < ready_pct);
      start = stray && (($urandom % 4) == 0);
      total = NW'($urandom % 500);
      if (chunk_ready) begin
        sum += exp_len;
        left -= exp_len;
        exp_base += exp_len;
        exp_len = MVL;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chunk_ready = 1'b0;
    chk(sum == n, "R5 sum", sum, n);
    chk(done == 1'b1, "R8 done", int'(done), 1);
    chk(chunk_valid == 1'b0, "R8 valid low", int'(chunk_valid), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10 done sticky", int'(done), 1);
    chk(chunk_valid == 1'b0, "R10 idle", int'(chunk_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(chunk_valid == 1'b0, "R1 valid", int'(chunk_valid), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    rst_n = 1'b1;
    run(166, 100, 0);
    run(0, 100, 0);
    run(16, 100, 0);
    run(32, 60, 0);
    run(1, 50, 0);
    run(15, 100, 0);
    run(17, 40, 1);
    run(166, 50, 1);
    run(48, 30, 1);
    for (int i = 0; i < 25; i++)
      run(int'($urandom % 400), 20 + int'($urandom % 81), 1);
    run(0, 100, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule